// File: doc/BRIEF.md
# IP TCP/UDP checksum checker

This block observes an Ethernet frame while it is received as a stream of bytes. It looks for an IPv4 or IPv6 packet that carries TCP or UDP. When it finds one, it adds up the pseudo-header and the whole transport segment in one's-complement arithmetic. At the end of the frame it emits a single 32-bit status word together with a one-cycle strobe. That word reports the IP version, the transport type, whether the packet is a fragment, whether the checksum failed, and the raw 16-bit sum.

The receive path drives the byte stream with start-of-frame, end-of-frame and valid qualifiers. The checker taps the stream and never stalls it, and it holds no frame data. A receiving transport segment with a correct checksum field always sums to FFFFh. Downstream logic can therefore accept the packet from the error flag alone, or it can take the raw sum for its own use.

Top module: `cksum_checker`

## Requirements
- R1: An IPv4 packet is recognised when frame bytes 12–13 hold EtherType 0x0800, the first IP byte has version 4 and a header length of at least 5 words, and the protocol byte (IP offset 9) is 6 or 17. Status bit 20 is then set and bit 19 is clear.
- R2: An IPv6 packet is recognised when the EtherType is 0x86DD, the version nibble is 6, and the next-header byte (IP offset 6) is 6 or 17. Status bit 19 is then set and bit 20 is clear. Any other next-header value is treated as undetected.
- R3: One 802.1Q tag (0x8100 at bytes 12–13) is skipped. The EtherType is then read at bytes 16–17, and the IP header starts at byte 18 instead of byte 14.
- R4: Status bit 18 is 1 for TCP (protocol 6) and 0 for UDP (protocol 17).
- R5: Status bits 15:0 hold the one's-complement sum, with the end-around carry folded on every addition. The sum covers the source and destination addresses, the protocol number, the transport length, and every transport byte. Even-offset bytes are weighted as the high byte, and an odd trailing byte is padded with a zero low byte. The transport length is the IPv4 total length minus the header length, or the IPv6 payload length. Bytes after that extent (padding, FCS) are not summed.
- R6: Status bit 16 is set for a non-fragment packet when the sum differs from FFFFh, or when the frame ends before the last transport byte.
- R7: An IPv4 packet is a fragment when the MF flag (bit 5 of IP byte 6) is set or the 13-bit fragment offset is nonzero. The status then has bit 17 set and bit 16 clear, and the sum is still reported. IPv6 packets never report a fragment.
- R8: A frame that is not recognised yields an all-zero status word. This covers another EtherType, a bad version or header length, another protocol, and a frame that ends before the protocol byte.
- R9: Status bits 31:21 are always zero.
- R10: `statValid` is high for exactly one cycle, after the second rising edge that follows the accepted end-of-frame beat. `statWord` keeps its value until the next status.
- R11: A beat with `inValid` low has no effect. So does a beat that arrives outside a frame without start-of-frame. A start-of-frame in the middle of a frame abandons the old frame, which yields no status.
- R12: After reset, `statValid` and `statWord` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte beat qualifier |
| inSof | input | 1 | Beat is the first byte of a frame |
| inEof | input | 1 | Beat is the last byte of a frame |
| inData | input | 8 | Frame byte |
| statValid | output | 1 | One-cycle strobe for a new status word |
| statWord | output | 32 | Packed status word |

## Verification
Parser position is the riskiest internal state. If the byte position or the IP header base is off by one, the pseudo-header and transport windows shift. The sum then moves away from FFFFh, so a good packet shows a checksum error in the first status word after that frame. A wrong classification state either sets the version flags on a non-matching frame or clears them on a matching one; both show at the strobe of the same frame. A wrong accumulator clear or wrong beat gating only shows on the following frame, so the stimulus runs many frames back to back, with idle gaps, stray beats and an abandoned frame in between.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

  localparam logic [15:0] ET_TAG  = 16'h8100;
  localparam logic [15:0] ET_IPV4 = 16'h0800;
  localparam logic [15:0] ET_IPV6 = 16'h86DD;
  localparam logic [7:0]  PROTO_TCP = 8'd6;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam int ETH_TYPE_POS  = 12;
  localparam int TAG_LEN       = 4;
  localparam int V4_MIN_IHL    = 5;
  localparam int V4_ADDR_LO    = 12;
  localparam int V4_ADDR_HI    = 20;
  localparam int V6_ADDR_LO    = 8;
  localparam int V6_HDR_BYTES  = 40;

  typedef enum logic [2:0] {
    K_ETH, K_TAG, K_V4, K_V6, K_V4OK, K_V6OK, K_NONE
  } kind_e;

  typedef struct packed {
    logic clear;
    logic sumEn;
    logic sumHigh;
    logic finish;
  } ctlStrobe_t;

  typedef struct packed {
    logic        isV4;
    logic        isV6;
    logic        tcp;
    logic        frag;
    logic        complete;
    logic [7:0]  proto;
    logic [15:0] l4Len;
  } hdrInfo_t;

  function automatic logic [15:0] onesAdd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'b0, s[16]};
  endfunction

endpackage

// File: rtl/cksum_parse_ctl.sv
module cksum_parse_ctl
  import cksum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [7:0]       inData,
  output ctlStrobe_t       strobe,
  output hdrInfo_t         info
);

  localparam int EW = CNT_W + 1;
  localparam logic [CNT_W-1:0] BASE_PLAIN = CNT_W'(ETH_TYPE_POS + 2);
  localparam logic [CNT_W-1:0] BASE_TAG   = CNT_W'(ETH_TYPE_POS + 2 + TAG_LEN);
  localparam logic [CNT_W-1:0] POS_ET_HI  = CNT_W'(ETH_TYPE_POS);
  localparam logic [CNT_W-1:0] POS_ET_LO  = CNT_W'(ETH_TYPE_POS + 1);
  localparam logic [CNT_W-1:0] POS_TET_HI = CNT_W'(ETH_TYPE_POS + TAG_LEN);
  localparam logic [CNT_W-1:0] POS_TET_LO = CNT_W'(ETH_TYPE_POS + TAG_LEN + 1);
  localparam logic [CNT_W-1:0] V4_PS_LO   = CNT_W'(V4_ADDR_LO);
  localparam logic [CNT_W-1:0] V4_PS_HI   = CNT_W'(V4_ADDR_HI);
  localparam logic [CNT_W-1:0] V6_PS_LO   = CNT_W'(V6_ADDR_LO);
  localparam logic [CNT_W-1:0] V6_PS_HI   = CNT_W'(V6_HDR_BYTES);

  logic             inFrame;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] l3Base;
  kind_e            kind;
  logic [7:0]       etHi;
  logic [7:0]       lenHi;
  logic [5:0]       hdrBytes;
  logic [15:0]      ipLen;
  logic [15:0]      l4Len;
  logic [EW-1:0]    endOff;
  logic [7:0]       proto;
  logic             tcp;
  logic             frag;
  logic             complete;
  logic             finishQ;

  logic             active;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] l3Off;
  logic [EW-1:0]    l3Ext;
  kind_e            kEff;
  logic             okState;
  logic             inPseudo;
  logic             inL4;
  logic [CNT_W-1:0] l4Start;
  logic             sumEn;
  logic [15:0]      typeWord;
  logic             protoOk;

  always_comb begin
    active   = inValid && (inSof || inFrame);
    idx      = inSof ? '0 : byteCnt;
    kEff     = inSof ? K_ETH : kind;
    l3Off    = idx - l3Base;
    l3Ext    = {1'b0, l3Off};
    typeWord = {etHi, inData};
    protoOk  = (inData == PROTO_TCP) || (inData == PROTO_UDP);
    okState  = (kEff == K_V4OK) || (kEff == K_V6OK);
    if (kEff == K_V4OK) begin
      inPseudo = (l3Off >= V4_PS_LO) && (l3Off < V4_PS_HI);
      l4Start  = CNT_W'(hdrBytes);
    end else begin
      inPseudo = (l3Off >= V6_PS_LO) && (l3Off < V6_PS_HI);
      l4Start  = V6_PS_HI;
    end
    inL4  = (l3Off >= l4Start) && (l3Ext < endOff);
    sumEn = active && !inSof && okState && (inPseudo || inL4);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      byteCnt  <= '0;
      l3Base   <= '0;
      kind     <= K_NONE;
      etHi     <= '0;
      lenHi    <= '0;
      hdrBytes <= '0;
      ipLen    <= '0;
      l4Len    <= '0;
      endOff   <= '0;
      proto    <= '0;
      tcp      <= 1'b0;
      frag     <= 1'b0;
      complete <= 1'b0;
      finishQ  <= 1'b0;
    end else begin
      finishQ <= active && inEof;
      if (active) begin
        byteCnt <= (idx == '1) ? idx : idx + 1'b1;
        inFrame <= !inEof;
        if (inSof) begin
          kind     <= K_ETH;
          tcp      <= 1'b0;
          frag     <= 1'b0;
          complete <= 1'b0;
        end
        unique case (kEff)
          K_ETH: begin
            if (idx == POS_ET_HI) etHi <= inData;
            else if (idx == POS_ET_LO) begin
              l3Base <= BASE_PLAIN;
              if (typeWord == ET_IPV4)      kind <= K_V4;
              else if (typeWord == ET_IPV6) kind <= K_V6;
              else if (typeWord == ET_TAG)  kind <= K_TAG;
              else                          kind <= K_NONE;
            end
          end
          K_TAG: begin
            if (idx == POS_TET_HI) etHi <= inData;
            else if (idx == POS_TET_LO) begin
              l3Base <= BASE_TAG;
              if (typeWord == ET_IPV4)      kind <= K_V4;
              else if (typeWord == ET_IPV6) kind <= K_V6;
              else                          kind <= K_NONE;
            end
          end
          K_V4: begin
            case (l3Off)
              CNT_W'(0): begin
                if (inData[7:4] != 4'd4 || inData[3:0] < 4'(V4_MIN_IHL)) kind <= K_NONE;
                hdrBytes <= {inData[3:0], 2'b00};
              end
              CNT_W'(2): lenHi <= inData;
              CNT_W'(3): ipLen <= {lenHi, inData};
              CNT_W'(6): frag  <= inData[5] | (inData[4:0] != 5'd0);
              CNT_W'(7): frag  <= frag | (inData != 8'd0);
              CNT_W'(9): begin
                if (protoOk && (ipLen >= 16'(hdrBytes))) begin
                  kind     <= K_V4OK;
                  proto    <= inData;
                  tcp      <= (inData == PROTO_TCP);
                  l4Len    <= ipLen - 16'(hdrBytes);
                  endOff   <= EW'(ipLen);
                  complete <= (ipLen == 16'(hdrBytes));
                end else begin
                  kind <= K_NONE;
                end
              end
              default: ;
            endcase
          end
          K_V6: begin
            case (l3Off)
              CNT_W'(0): if (inData[7:4] != 4'd6) kind <= K_NONE;
              CNT_W'(4): lenHi <= inData;
              CNT_W'(5): begin
                l4Len  <= {lenHi, inData};
                endOff <= EW'(V6_HDR_BYTES) + EW'({lenHi, inData});
              end
              CNT_W'(6): begin
                if (protoOk) begin
                  kind     <= K_V6OK;
                  proto    <= inData;
                  tcp      <= (inData == PROTO_TCP);
                  complete <= (l4Len == 16'd0);
                end else begin
                  kind <= K_NONE;
                end
              end
              default: ;
            endcase
          end
          K_V4OK, K_V6OK: begin
            if (sumEn && inL4 && ((l3Ext + 1'b1) == endOff)) complete <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.clear   = active && inSof;
    strobe.sumEn   = sumEn;
    strobe.sumHigh = ~l3Off[0];
    strobe.finish  = finishQ;
    info.isV4      = (kind == K_V4OK);
    info.isV6      = (kind == K_V6OK);
    info.tcp       = tcp;
    info.frag      = frag;
    info.complete  = complete;
    info.proto     = proto;
    info.l4Len     = l4Len;
  end

endmodule

// File: rtl/cksum_sum_dp.sv
module cksum_sum_dp
  import cksum_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  strobe,
  input  hdrInfo_t    info,
  input  logic [7:0]  inData,
  output logic        statValid,
  output logic [31:0] statWord
);

  logic [15:0] acc;
  logic [15:0] addend;
  logic [15:0] withProto;
  logic [15:0] total;
  logic        detected;
  logic        sumErr;

  always_comb begin
    addend    = strobe.sumHigh ? {inData, 8'h00} : {8'h00, inData};
    withProto = onesAdd(acc, {8'h00, info.proto});
    total     = onesAdd(withProto, info.l4Len);
    detected  = info.isV4 | info.isV6;
    sumErr    = !info.frag && ((total != 16'hFFFF) || !info.complete);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      statValid <= 1'b0;
      statWord  <= '0;
    end else begin
      if (strobe.clear)      acc <= '0;
      else if (strobe.sumEn) acc <= onesAdd(acc, addend);
      statValid <= strobe.finish;
      if (strobe.finish) begin
        statWord <= detected ? {11'b0, info.isV4, info.isV6, info.tcp, info.frag, sumErr, total}
                             : 32'h0;
      end
    end
  end

endmodule

// File: rtl/cksum_checker.sv
module cksum_checker
  import cksum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic [7:0]  inData,
  output logic        statValid,
  output logic [31:0] statWord
);

  ctlStrobe_t strobe;
  hdrInfo_t   info;

  cksum_parse_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof),
    .inEof(inEof), .inData(inData), .strobe(strobe), .info(info)
  );

  cksum_sum_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .info(info),
    .inData(inData), .statValid(statValid), .statWord(statWord)
  );

endmodule

// File: rtl/cksum_checker_sva.sv
module cksum_checker_sva (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inEof,
  input logic        statValid,
  input logic [31:0] statWord
);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> statWord[31:21] == 11'd0);

  p_one_version_r1: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> !(statWord[20] && statWord[19]));

  p_undetected_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && !statWord[20] && !statWord[19]) |-> statWord[18:0] == 19'd0);

  p_frag_no_error_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statWord[17]) |-> !statWord[16]);

  p_v6_no_frag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statWord[19]) |-> !statWord[17]);

  p_bad_sum_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && (statWord[20] || statWord[19]) && !statWord[17] && statWord[15:0] != 16'hFFFF)
      |-> statWord[16]);

  p_after_eof_r10: assert property (@(posedge clk) disable iff (!rstN)
    statValid |-> $past(inValid && inEof, 2));

  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rstN)
    !statValid |-> $stable(statWord));

endmodule

bind cksum_checker cksum_checker_sva u_sva (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEof(inEof),
  .statValid(statValid), .statWord(statWord)
);

// File: tb/cksum_checker_test.sv
module cksum_checker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inSof = 1'b0;
  logic        inEof = 1'b0;
  logic [7:0]  inData = 8'h0;
  logic        statValid;
  logic [31:0] statWord;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] frm [0:511];
  int frmLen, l3B, bHdrB, bL4Len, bProto;
  bit bV6, bFrag, bDetect;

  always #5 clk = ~clk;

  cksum_checker uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .statValid(statValid), .statWord(statWord)
  );

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      finishRun();
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fold32(logic [31:0] s);
    logic [31:0] t = s;
    while (t[31:16] != 0) t = {16'h0, t[15:0]} + {16'h0, t[31:16]};
    return t[15:0];
  endfunction

  // Independent reference: word-wise 32-bit sum, folded once at the end.
  function automatic logic [15:0] calcSum(int limit);
    logic [31:0] s = 0;
    int ps = bV6 ? 8 : 12;
    int pn = bV6 ? 32 : 8;
    int l4s = l3B + (bV6 ? 40 : bHdrB);
    for (int i = 0; i < pn; i += 2) s += {16'h0, frm[l3B+ps+i], frm[l3B+ps+i+1]};
    s += 32'(bProto);
    s += 32'(bL4Len);
    for (int k = 0; k < bL4Len; k++) begin
      if (l4s + k < limit) begin
        if (k % 2 == 0) s += {16'h0, frm[l4s+k], 8'h00};
        else            s += {24'h0, frm[l4s+k]};
      end
    end
    return fold32(s);
  endfunction

  function automatic logic [31:0] expWordCalc(int limit);
    logic [15:0] sum;
    bit err;
    int l4End = l3B + (bV6 ? 40 : bHdrB) + bL4Len;
    if (!bDetect) return 32'h0;
    if (limit <= l3B + (bV6 ? 6 : 9)) return 32'h0;
    sum = calcSum(limit);
    err = !bFrag && ((sum != 16'hFFFF) || (limit < l4End));
    return {11'h0, !bV6, bV6, (bProto == 6), bFrag, err, sum};
  endfunction

  task automatic buildFrame(bit v6, bit vlan, int proto, int ihl, int l4Len,
                            int fragMode, bit corrupt, int pad);
    int csOff;
    logic [15:0] s;
    bV6 = v6; bProto = proto; bL4Len = l4Len;
    bHdrB = v6 ? 40 : ihl * 4;
    bFrag = !v6 && (fragMode != 0);
    bDetect = (proto == 6) || (proto == 17);
    for (int i = 0; i < 512; i++) frm[i] = 8'($urandom);
    l3B = vlan ? 18 : 14;
    if (vlan) begin frm[12] = 8'h81; frm[13] = 8'h00; end
    frm[l3B-2] = v6 ? 8'h86 : 8'h08;
    frm[l3B-1] = v6 ? 8'hDD : 8'h00;
    if (v6) begin
      frm[l3B]   = 8'h60 | (frm[l3B] & 8'h0F);
      frm[l3B+4] = 8'(l4Len >> 8);
      frm[l3B+5] = 8'(l4Len);
      frm[l3B+6] = 8'(proto);
    end else begin
      frm[l3B]   = 8'h40 | 8'(ihl);
      frm[l3B+2] = 8'((bHdrB + l4Len) >> 8);
      frm[l3B+3] = 8'(bHdrB + l4Len);
      frm[l3B+6] = (fragMode == 1) ? 8'h20 : (fragMode == 2) ? 8'h00 : 8'h40;
      frm[l3B+7] = (fragMode == 2) ? 8'h08 : 8'h00;
      frm[l3B+9] = 8'(proto);
    end
    frmLen = l3B + bHdrB + l4Len + pad;
    csOff = l3B + bHdrB + ((proto == 6) ? 16 : 6);
    if (bDetect && (csOff + 2 <= l3B + bHdrB + l4Len)) begin
      frm[csOff] = 8'h00; frm[csOff+1] = 8'h00;
      s = ~calcSum(512);
      if (corrupt) s = s ^ 16'h0001;
      frm[csOff] = s[15:8]; frm[csOff+1] = s[7:0];
    end
  endtask

  task automatic sendBeats(int len, bit gaps, bit withEof);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        inValid = 1'b0; inSof = 1'($urandom); inEof = 1'($urandom); inData = 8'($urandom);
        @(negedge clk);
      end
      inValid = 1'b1; inSof = (i == 0); inEof = withEof && (i == len - 1); inData = frm[i];
      @(negedge clk);
    end
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  // R10 timing: pulse after the second rising edge following the EOF beat.
  task automatic runFrame(string tag, int limit, bit gaps);
    logic [31:0] exp = expWordCalc(limit);
    logic [31:0] held;
    sendBeats(limit - 1, gaps, 1'b0);
    inValid = 1'b1; inSof = (limit == 1); inEof = 1'b1; inData = frm[limit-1];
    @(negedge clk);
    inValid = 1'b0; inEof = 1'b0;
    chk(statValid == 1'b0, "R10 early strobe", 32'(statValid), 32'h0);
    @(negedge clk);
    chk(statValid == 1'b1, "R10 strobe", 32'(statValid), 32'h1);
    chk(statWord == exp, tag, statWord, exp);
    held = statWord;
    @(negedge clk);
    chk(statValid == 1'b0 && statWord == held, "R10 single pulse and hold", statWord, held);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(statValid == 1'b0, "R12 reset strobe", 32'(statValid), 32'h0);
    chk(statWord == 32'h0, "R12 reset word", statWord, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    buildFrame(0, 0, 6, 5, 40, 0, 0, 4);
    runFrame("R1 R4 R5 ipv4 tcp good", frmLen, 0);
    buildFrame(0, 0, 17, 6, 41, 0, 0, 0);
    runFrame("R5 odd trailing byte udp", frmLen, 0);
    buildFrame(1, 1, 17, 5, 30, 0, 0, 3);
    runFrame("R2 R3 ipv6 udp tagged", frmLen, 1);
    buildFrame(0, 1, 6, 7, 60, 0, 1, 2);
    runFrame("R3 R6 tagged ipv4 bad checksum", frmLen, 0);
    buildFrame(0, 0, 17, 5, 32, 1, 1, 0);
    runFrame("R7 MF fragment", frmLen, 0);
    buildFrame(0, 0, 6, 5, 32, 2, 0, 0);
    runFrame("R7 offset fragment", frmLen, 0);
    buildFrame(1, 0, 58, 5, 24, 0, 0, 0);
    runFrame("R2 R8 ipv6 other next header", frmLen, 0);
    buildFrame(0, 0, 1, 5, 24, 0, 0, 0);
    runFrame("R8 ipv4 other protocol", frmLen, 0);
    buildFrame(0, 0, 6, 5, 40, 0, 0, 0);
    frm[l3B] = 8'h44; bDetect = 0;
    runFrame("R8 header length below minimum", frmLen, 0);
    buildFrame(0, 0, 17, 5, 40, 0, 0, 0);
    frm[12] = 8'h08; frm[13] = 8'h06; bDetect = 0;
    runFrame("R8 other EtherType", frmLen, 0);
    buildFrame(0, 0, 6, 5, 40, 0, 0, 0);
    runFrame("R8 ends before protocol", l3B + 5, 0);
    buildFrame(0, 0, 17, 5, 40, 0, 0, 0);
    runFrame("R6 truncated transport", l3B + 20 + 20, 0);

    // R11: stray beats outside a frame, including EOF, must not produce status.
    for (int i = 0; i < 4; i++) begin
      inValid = 1'b1; inSof = 1'b0; inEof = 1'b1; inData = 8'($urandom);
      @(negedge clk);
    end
    inValid = 1'b0; inEof = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(statValid == 1'b0, "R11 stray beats ignored", 32'(statValid), 32'h0);
      @(negedge clk);
    end

    // R11: abandoned frame restarted by a new start-of-frame.
    buildFrame(1, 0, 6, 5, 50, 0, 1, 0);
    sendBeats(30, 0, 1'b0);
    chk(statValid == 1'b0, "R11 abandoned frame no status", 32'(statValid), 32'h0);
    buildFrame(0, 0, 6, 5, 44, 0, 0, 1);
    runFrame("R11 restart then ipv4 tcp", frmLen, 1);

    for (int n = 0; n < 60; n++) begin
      int r = $urandom % 10;
      bit v6 = 1'($urandom);
      int proto = (r == 1) ? 1 : (($urandom % 2) ? 6 : 17);
      int l4 = (proto == 6) ? 20 + $urandom % 100 : 8 + $urandom % 100;
      int fm = (!v6 && ($urandom % 6 == 0)) ? 1 + $urandom % 2 : 0;
      buildFrame(v6, 1'($urandom), proto, 5 + $urandom % 4, l4, fm,
                 ($urandom % 3 == 0), $urandom % 6);
      if (r == 0) begin frm[l3B-2] = 8'h88; frm[l3B-1] = 8'hCC; bDetect = 0; end
      runFrame("R1 R2 R4 R5 R6 R9 random frame", frmLen, 1'($urandom));
    end

    finishRun();
  end

endmodule